// File: doc/BRIEF.md
# Incremental Character Display Refresher

This block keeps a character display of fixed size in step with a local shadow copy of its contents, while never spending more than one character transfer per scheduler tick. A host writes characters into the shadow store through a simple write port. Each write also flags that position as stale. A periodic tick input paces the refresh. On a tick, if no transfer is outstanding, the block looks for the next stale position and presents that position and its character to the display side. The search starts just after the position it sent last and wraps around.

The display side answers each request with an acknowledge. A character write on a real panel takes a long time compared with the clock, so the request and its payload stay put until that acknowledge comes back. Positions that are not stale are skipped. A full repaint of every position therefore costs at most one tick per position, and a panel with few changes costs only a few ticks. After reset every position reads as a blank and is flagged stale, so the first ticks paint the whole panel once.

Top module: `disp_refresh`

## Requirements
- R1: During and right after reset `disp_req` is low. Every position then holds the fill character (0x20 by default) and is stale, so the first pass sends positions 0, 1, … 39 in that order, each carrying 0x20.
- R2: A transfer starts only on a cycle where `tick` is high, no request is outstanding and at least one position is stale. `disp_req` rises on the cycle after that tick. A tick with nothing stale starts nothing.
- R3: While `disp_req` is high and `disp_ack` is low, `disp_req`, `disp_pos` and `disp_char` hold their values. `disp_req` falls on the cycle after the one where `disp_ack` is seen high with it.
- R4: A tick that comes while a request is outstanding is ignored, including a tick in the acknowledge cycle itself. No transfer is queued for it, and requests are never back to back.
- R5: Only stale positions are sent. A position that has not been written since it was last sent is skipped.
- R6: The search for a stale position starts at the position after the one sent last, wrapping from 39 to 0. A position rewritten over and over cannot block the others.
- R7: A host write (`host_we` high, `host_pos` < 40) stores `host_char` at `host_pos` and marks that position stale. The character sent is the one stored before the cycle of the launching tick.
- R8: A host write to a position after its transfer has been launched, or in the launch cycle itself, marks it stale again. The newer character is sent by a later tick.
- R9: A host write with `host_pos` of 40 or more (the port is 6 bits wide) changes nothing and causes no transfer.
- R10: When every position is stale and each request is acknowledged before the next tick, the whole display is sent in exactly 40 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Scheduler tick, one-cycle pulse or level |
| host_we | input | 1 | Host write strobe |
| host_pos | input | 6 | Host write position |
| host_char | input | 8 | Host write character |
| disp_req | output | 1 | Transfer request to the display side |
| disp_pos | output | 6 | Position of the character being sent |
| disp_char | output | 8 | Character being sent |
| disp_ack | input | 1 | Display-side acknowledge of the current request |

## Verification
If the stale flags are corrupted, the wrong positions are sent. A flag lost by mistake shows up as a position that is never sent, and a flag that is never cleared shows up as a repeated send. Either one appears on `disp_pos` within one tick of the point where the scan would reach that position. A wrong scan pointer breaks the wrap-around order on the very next launch. A wrong shadow entry, or a wrong blank-fill flag, shows up on `disp_char` the first time that position is sent. The reference model predicts the request line, position and character for every cycle, so any such fault is flagged on the first cycle where the outputs differ.

// File: rtl/disp_refresh_pkg.sv
package disp_refresh_pkg;

  // Modular add used by the round-robin scan: (base + off) wrapped into [0, limit).
  function automatic int unsigned wrap_add(input int unsigned base,
                                           input int unsigned off,
                                           input int unsigned limit);
    int unsigned s;
    s = base + off;
    return (s >= limit) ? s - limit : s;
  endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N  = 40,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] start,
  output logic          hit,
  output logic [IW-1:0] sel
);
  import disp_refresh_pkg::*;

  // Walk from the farthest offset down to offset 0, so the candidate
  // nearest to start is assigned last and wins.
  always_comb begin
    int unsigned idx;
    hit = 1'b0;
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      idx = wrap_add(32'(start), unsigned'(i), unsigned'(N));
      if (cand[idx]) begin
        hit = 1'b1;
        sel = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/pos_flags.sv
module pos_flags #(
  parameter int N  = 40,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  stale,
  output logic [N-1:0]  loaded
);
  // One stale flag and one "host has written this" flag per position.
  // A set from the host takes priority over a clear from a launch.
  for (genvar g = 0; g < N; g++) begin : g_pos
    logic stale_q, loaded_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        stale_q  <= 1'b1;
        loaded_q <= 1'b0;
      end else begin
        if (set_en && set_idx == IW'(g)) begin
          stale_q  <= 1'b1;
          loaded_q <= 1'b1;
        end else if (clr_en && clr_idx == IW'(g)) begin
          stale_q  <= 1'b0;
        end
      end
    end
    assign stale[g]  = stale_q;
    assign loaded[g] = loaded_q;
  end
endmodule

// File: rtl/shadow_ram.sv
module shadow_ram #(
  parameter int DEPTH = 40,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rq
);
  // Simple dual-port, read-first, registered read with enable.
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rq <= mem[ra];
  end
endmodule

// File: rtl/disp_refresh.sv
module disp_refresh #(
  parameter int NUM_POS   = 40,
  parameter int CHAR_W    = 8,
  parameter int FILL_CHAR = 32,
  localparam int PW       = $clog2(NUM_POS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              host_we,
  input  logic [PW-1:0]     host_pos,
  input  logic [CHAR_W-1:0] host_char,
  output logic              disp_req,
  output logic [PW-1:0]     disp_pos,
  output logic [CHAR_W-1:0] disp_char,
  input  logic              disp_ack
);
  localparam logic [PW-1:0]     LAST_POS = PW'(NUM_POS - 1);
  localparam logic [CHAR_W-1:0] FILL     = CHAR_W'(FILL_CHAR);

  logic [NUM_POS-1:0] stale, loaded;
  logic               host_ok, hit, launch;
  logic [PW-1:0]      pick, ptr_q, pos_q;
  logic               req_q, fill_q;
  logic [CHAR_W-1:0]  ram_q;

  assign host_ok = host_we && (32'(host_pos) < NUM_POS);
  assign launch  = tick && !req_q && hit;

  rr_pick #(.N(NUM_POS), .IW(PW)) u_pick (
    .cand (stale),
    .start(ptr_q),
    .hit  (hit),
    .sel  (pick)
  );

  pos_flags #(.N(NUM_POS), .IW(PW)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_en (host_ok),
    .set_idx(host_pos),
    .clr_en (launch),
    .clr_idx(pick),
    .stale  (stale),
    .loaded (loaded)
  );

  shadow_ram #(.DEPTH(NUM_POS), .AW(PW), .DW(CHAR_W)) u_ram (
    .clk(clk),
    .we (host_ok),
    .wa (host_pos),
    .wd (host_char),
    .re (launch),
    .ra (pick),
    .rq (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      pos_q  <= '0;
      ptr_q  <= '0;
      fill_q <= 1'b1;
    end else begin
      if (launch) begin
        req_q  <= 1'b1;
        pos_q  <= pick;
        fill_q <= !loaded[pick];
        ptr_q  <= (pick == LAST_POS) ? '0 : pick + 1'b1;
      end else if (req_q && disp_ack) begin
        req_q <= 1'b0;
      end
    end
  end

  assign disp_req  = req_q;
  assign disp_pos  = pos_q;
  assign disp_char = fill_q ? FILL : ram_q;

  // R3: request and payload hold until acknowledged
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    disp_req && !disp_ack |=> disp_req && $stable(disp_pos) && $stable(disp_char));

  // R3: request drops right after the acknowledge; R4: no back-to-back start
  assert_drop_after_ack_R4: assert property (@(posedge clk) disable iff (rst)
    disp_req && disp_ack |=> !disp_req);

  // R2: a new request is always caused by a tick
  assert_launch_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(disp_req) |-> $past(tick));

  // R9: a position outside the display is never sent
  assert_pos_in_range_R9: assert property (@(posedge clk) disable iff (rst)
    disp_req |-> (32'(disp_pos) < NUM_POS));

  // R6: consecutive launches never pick the same position while others wait
  assert_scan_advances_R6: assert property (@(posedge clk) disable iff (rst)
    launch && $countones(stale) > 1 |-> pick != $past(disp_pos) || !$past(disp_req) || $past(rst));
endmodule

// File: tb/disp_refresh_tb.sv
`timescale 1ns/1ps
module disp_refresh_tb;
  localparam int N = 40;

  logic       clk = 1'b0;
  logic       rst;
  logic       tick, host_we, disp_ack, disp_req;
  logic [5:0] host_pos, disp_pos;
  logic [7:0] host_char, disp_char;

  always #4 clk = ~clk;

  disp_refresh u_dut (
    .clk(clk), .rst(rst), .tick(tick), .host_we(host_we), .host_pos(host_pos),
    .host_char(host_char), .disp_req(disp_req), .disp_pos(disp_pos),
    .disp_char(disp_char), .disp_ack(disp_ack)
  );

  // reference model state
  logic [7:0] m_shadow [N];
  bit         m_stale  [N];
  int         m_ptr, m_pos, m_age;
  bit         m_req;
  logic [7:0] m_char;

  int    n_chk = 0, n_fail = 0, ack_dly = 1;
  string tag = "R1";
  int    sent_pos[$];
  int    sent_chr[$];
  bit    done = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_shadow[i] = 8'h20;
      m_stale[i]  = 1'b1;
    end
    m_ptr = 0; m_req = 0; m_pos = 0; m_char = 8'h20; m_age = 0;
  endtask

  // One clock cycle: called at a falling edge, returns at the next falling edge.
  task automatic step(input bit t, input bit we, input int p, input int c);
    bit ack_now, found;
    int pk;
    n_chk++;
    if (disp_req !== m_req || (m_req && (disp_pos !== 6'(m_pos) || disp_char !== m_char))) begin
      n_fail++;
      $display("FAIL %s cycle compare: actual req=%0d pos=%0d char=%0h expected req=%0d pos=%0d char=%0h",
               tag, disp_req, disp_pos, disp_char, m_req, m_pos, m_char);
    end
    ack_now = m_req && (m_age >= ack_dly);
    if (disp_req && ack_now) begin
      sent_pos.push_back(int'(disp_pos));
      sent_chr.push_back(int'(disp_char));
    end
    tick = t; host_we = we; host_pos = 6'(p); host_char = 8'(c); disp_ack = ack_now;
    // model next state
    found = 0; pk = 0;
    if (t && !m_req) begin
      for (int i = 0; i < N; i++) begin
        int k;
        k = (m_ptr + i) % N;
        if (!found && m_stale[k]) begin found = 1; pk = k; end
      end
    end
    if (m_req) begin
      m_age++;
      if (ack_now) m_req = 0;
    end else if (found) begin
      m_req = 1; m_pos = pk; m_char = m_shadow[pk]; m_stale[pk] = 0;
      m_ptr = (pk + 1) % N; m_age = 0;
    end
    if (we && p < N) begin
      m_shadow[p] = 8'(c);
      m_stale[p]  = 1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic drain();
    for (int i = 0; i < 60 && m_req; i++) step(0, 0, 0, 0);
    step(0, 0, 0, 0);
  endtask

  task automatic tick_drain();
    step(1, 0, 0, 0);
    drain();
  endtask

  task automatic wr(input int p, input int c);
    step(0, 1, p, c);
  endtask

  task automatic clear_log();
    sent_pos.delete();
    sent_chr.delete();
  endtask

  initial begin
    bit ok;
    tick = 0; host_we = 0; host_pos = 0; host_char = 0; disp_ack = 0;
    rst = 1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(disp_req == 1'b0, "R1", "req during reset", disp_req, 0);
    rst = 0;

    // R1 / R10: full initial paint, one tick per position
    tag = "R1";
    for (int i = 0; i < N; i++) tick_drain();
    chk(sent_pos.size() == N, "R10", "transfers after 40 ticks", sent_pos.size(), N);
    ok = 1;
    for (int i = 0; i < sent_pos.size(); i++)
      if (sent_pos[i] != i || sent_chr[i] != 8'h20) ok = 0;
    chk(ok, "R1", "initial pass order/blank", ok, 1);

    // R2: ticks with nothing stale start nothing
    tag = "R2"; clear_log();
    for (int i = 0; i < 5; i++) tick_drain();
    chk(sent_pos.size() == 0, "R2", "transfers with nothing stale", sent_pos.size(), 0);

    // R5 / R7: only written positions are sent, with their new characters
    tag = "R5"; clear_log();
    wr(30, 8'h41); wr(5, 8'h42);
    for (int i = 0; i < 4; i++) tick_drain();
    chk(sent_pos.size() == 2, "R5", "only stale sent (count)", sent_pos.size(), 2);
    if (sent_pos.size() == 2) begin
      chk(sent_pos[0] == 5 && sent_pos[1] == 30, "R5", "stale positions order", sent_pos[0], 5);
      chk(sent_chr[0] == 8'h42 && sent_chr[1] == 8'h41, "R7", "stored characters", sent_chr[0], 8'h42);
    end

    // R6: round-robin from after the last sent position (pointer is now 31)
    tag = "R6"; clear_log();
    wr(2, 8'h61); wr(35, 8'h62);
    tick_drain();
    wr(35, 8'h63);
    tick_drain();
    tick_drain();
    chk(sent_pos.size() == 3, "R6", "round-robin count", sent_pos.size(), 3);
    if (sent_pos.size() == 3) begin
      chk(sent_pos[0] == 35 && sent_pos[1] == 2 && sent_pos[2] == 35, "R6", "wrap order, no starvation",
          sent_pos[1], 2);
      chk(sent_chr[2] == 8'h63, "R7", "latest character sent", sent_chr[2], 8'h63);
    end

    // R8: rewrite while in flight, and in the launch cycle itself
    tag = "R8"; clear_log(); ack_dly = 6;
    wr(7, 8'h78);
    step(1, 0, 0, 0);
    step(0, 1, 7, 8'h79);
    drain();
    tick_drain();
    wr(8, 8'h70);
    step(1, 1, 8, 8'h71);
    drain();
    tick_drain();
    chk(sent_pos.size() == 4, "R8", "resend count", sent_pos.size(), 4);
    if (sent_pos.size() == 4) begin
      chk(sent_pos[1] == 7 && sent_chr[0] == 8'h78 && sent_chr[1] == 8'h79, "R8",
          "in-flight rewrite resent", sent_chr[1], 8'h79);
      chk(sent_pos[3] == 8 && sent_chr[2] == 8'h70 && sent_chr[3] == 8'h71, "R8",
          "same-cycle rewrite resent", sent_chr[3], 8'h71);
    end

    // R4 / R3: tick held high while requests are pending, long acknowledge
    tag = "R4"; clear_log(); ack_dly = 6;
    wr(20, 8'h31); wr(21, 8'h32); wr(22, 8'h33);
    for (int i = 0; i < 30; i++) step(1, 0, 0, 0);
    drain();
    chk(sent_pos.size() == 3, "R4", "transfers under constant tick", sent_pos.size(), 3);
    tag = "R3"; clear_log(); ack_dly = 12;
    wr(25, 8'h55);
    tick_drain();
    chk(sent_pos.size() == 1 && sent_chr[0] == 8'h55, "R3", "held payload delivered", sent_pos.size(), 1);

    // R9: out-of-range writes are ignored
    tag = "R9"; clear_log(); ack_dly = 1;
    wr(40, 8'h11); wr(63, 8'h12);
    tick_drain(); tick_drain();
    chk(sent_pos.size() == 0, "R9", "out-of-range write transfers", sent_pos.size(), 0);

    idle(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule